// File: doc/BRIEF.md
# Line-Granular Transfer Splitter with Write Grading

This block takes one byte-addressed transfer request (start address, byte length, read or write) and breaks it into a sequence of memory commands. Each command covers exactly one 128-byte line. A command carries the line-aligned address, a 128-bit byte enable mask, the bank the line maps to, a flag on the final command, and a command kind.

Writes are graded by how much of the line they touch. A write that fills the whole line goes out as a plain write. A partial write of moderate size goes out as a byte-masked write. A very small partial write goes out as a read-modify-write. Reads are always whole-line reads; the mask tells the consumer which bytes the caller wanted. Banks interleave at line granularity, so a long transfer walks through the banks in turn.

The request side is accepted only while the block is idle. The command side is a valid/ready stream that holds its contents steady while back-pressured. The data path, DRAM timing and controller queues are outside this block.

Top module: `line_cmd_splitter`

## Requirements
- R1: A request with non-zero length produces one command per 128-byte line touched, in ascending line order. Each command's address is the line-aligned address of its line. `cmd_last` is 1 only on the final command.
- R2: A write command whose line is fully covered has kind 1 (plain write).
- R3: A write command covering at least 16 and at most 127 bytes of its line has kind 2 (byte-masked write).
- R4: A write command covering fewer than 16 bytes of its line has kind 3 (read-modify-write).
- R5: Every read command has kind 0 whatever its coverage, and its mask shows the requested bytes of that line.
- R6: `cmd_bank` equals the line number modulo 16, which is address bits [10:7]. Successive commands of one transfer step the bank by one, wrapping from 15 to 0.
- R7: Bit i of `cmd_be` enables byte i of the line. The first command's mask starts at the start offset (address bits [6:0]). The last command's mask ends at the offset of the last requested byte. All other bit ranges are filled to the line edges.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, every command output holds its value into the next cycle.
- R9: A zero-length request is accepted, produces no command, and leaves `req_ready` at 1.
- R10: `req_ready` is 0 while a transfer has commands pending. It returns to 1 in the cycle after the final command is accepted.
- R11: Only the first and the last command of a transfer can have a partial mask; every command between them has all 128 bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_addr | input | 32 | Start byte address |
| req_len | input | 16 | Length in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_addr | output | 32 | Line-aligned address |
| cmd_kind | output | 2 | 0 read, 1 plain write, 2 byte-masked write, 3 read-modify-write |
| cmd_bank | output | 4 | Bank index of the line |
| cmd_be | output | 128 | Byte enable per line byte |
| cmd_last | output | 1 | Final command of the transfer |

## Verification
A single line can be both the first and the last command of a transfer. Its mask is then trimmed at both ends at once, and its grade depends on the combined span. The bench provokes this with short requests placed mid-line and across the 16-byte grading boundary. It also uses a request of a few bytes that straddles a line edge, which yields two read-modify-writes in a row. Each is judged against a bench model that derives the span, mask, grade and bank from the request alone. Random back-pressure on `cmd_ready` checks that a held command does not change.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_FULL  = 2'd1,
        KIND_MASK  = 2'd2,
        KIND_RMW   = 2'd3
    } cmd_kind_e;
endpackage

// File: rtl/lcs_mask_gen.sv
module lcs_mask_gen #(
    parameter int LINE_BYTES = 128,
    localparam int OFF_W = $clog2(LINE_BYTES)
) (
    input  logic [OFF_W-1:0]      lo,
    input  logic [OFF_W-1:0]      hi,
    output logic [LINE_BYTES-1:0] be,
    output logic [OFF_W:0]        count
);
    // one enable per byte lane: inside the inclusive window [lo, hi]
    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_lane
        assign be[i] = (OFF_W'(i) >= lo) && (OFF_W'(i) <= hi);
    end

    assign count = {1'b0, hi} - {1'b0, lo} + 1'b1;
endmodule

// File: rtl/lcs_classify.sv
module lcs_classify
    import lcs_pkg::*;
#(
    parameter int LINE_BYTES = 128,
    parameter int RMW_MIN    = 16,
    localparam int OFF_W = $clog2(LINE_BYTES)
) (
    input  logic            is_write,
    input  logic [OFF_W:0]  count,
    output cmd_kind_e       kind
);
    always_comb begin
        if (!is_write)
            kind = KIND_READ;
        else if (count == (OFF_W+1)'(LINE_BYTES))
            kind = KIND_FULL;
        else if (count >= (OFF_W+1)'(RMW_MIN))
            kind = KIND_MASK;
        else
            kind = KIND_RMW;
    end
endmodule

// File: rtl/lcs_bank_map.sv
module lcs_bank_map #(
    parameter int NUM_BANKS = 16,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic [BANK_W-1:0] line_low,
    output logic [BANK_W-1:0] bank
);
    // banks interleave per line: the low line-number bits pick the bank
    assign bank = line_low;
endmodule

// File: rtl/line_cmd_splitter.sv
module line_cmd_splitter
    import lcs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 128,
    parameter int NUM_BANKS  = 16,
    parameter int RMW_MIN    = 16,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  req_write,
    output logic                  cmd_valid,
    input  logic                  cmd_ready,
    output logic [ADDR_W-1:0]     cmd_addr,
    output logic [1:0]            cmd_kind,
    output logic [BANK_W-1:0]     cmd_bank,
    output logic [LINE_BYTES-1:0] cmd_be,
    output logic                  cmd_last
);
    typedef struct packed {
        logic              busy;
        logic              write;
        logic [ADDR_W-1:0] cur;   // next byte to cover
        logic [ADDR_W-1:0] fin;   // last byte of the transfer (inclusive)
    } state_t;

    state_t st_q, st_d;

    logic [LINE_W-1:0] cur_line, fin_line;
    logic              on_last;
    logic [OFF_W-1:0]  lo, hi;
    logic [OFF_W:0]    count;
    cmd_kind_e         kind;

    assign cur_line = st_q.cur[ADDR_W-1:OFF_W];
    assign fin_line = st_q.fin[ADDR_W-1:OFF_W];
    assign on_last  = (cur_line == fin_line);
    assign lo       = st_q.cur[OFF_W-1:0];
    assign hi       = on_last ? st_q.fin[OFF_W-1:0] : {OFF_W{1'b1}};

    lcs_mask_gen #(.LINE_BYTES(LINE_BYTES)) mask_i (
        .lo    (lo),
        .hi    (hi),
        .be    (cmd_be),
        .count (count)
    );

    lcs_classify #(.LINE_BYTES(LINE_BYTES), .RMW_MIN(RMW_MIN)) class_i (
        .is_write (st_q.write),
        .count    (count),
        .kind     (kind)
    );

    lcs_bank_map #(.NUM_BANKS(NUM_BANKS)) bank_i (
        .line_low (cur_line[BANK_W-1:0]),
        .bank     (cmd_bank)
    );

    assign req_ready = !st_q.busy;
    assign cmd_valid = st_q.busy;
    assign cmd_addr  = {cur_line, {OFF_W{1'b0}}};
    assign cmd_kind  = kind;
    assign cmd_last  = on_last;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (req_valid && (req_len != '0)) begin
                st_d.busy  = 1'b1;
                st_d.write = req_write;
                st_d.cur   = req_addr;
                st_d.fin   = req_addr + ADDR_W'(req_len) - 1'b1;
            end
        end else if (cmd_ready) begin
            if (on_last)
                st_d.busy = 1'b0;
            else
                st_d.cur = {cur_line + 1'b1, {OFF_W{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R8: a held command does not move
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_be)
                                    && $stable(cmd_kind) && $stable(cmd_last));

    // R6: banks step by one through a transfer
    p_bank_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && !cmd_last |=> cmd_bank == $past(cmd_bank) + 1'b1);

    // R2: a plain write has every lane enabled
    p_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == 2'd1 |-> &cmd_be);

    // R4: a read-modify-write touches fewer than RMW_MIN bytes
    p_rmw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == 2'd3 |-> $countones(cmd_be) < RMW_MIN);

    // R3: a byte-masked write lies between the threshold and a full line
    p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == 2'd2 |-> ($countones(cmd_be) >= RMW_MIN) && !(&cmd_be));

    // R7: every non-final command reaches the top lane
    p_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_last |-> cmd_be[LINE_BYTES-1]);

    // R10: the block is free again right after the final command leaves
    p_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_last |=> req_ready);

    // R9: a zero-length request issues nothing
    p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_len == '0 |=> !cmd_valid);
endmodule

// File: tb/line_cmd_splitter_tb_top.sv
module line_cmd_splitter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [15:0]  req_len = '0;
    logic         req_write = 1'b0;
    logic         cmd_valid;
    logic         cmd_ready = 1'b0;
    logic [31:0]  cmd_addr;
    logic [1:0]   cmd_kind;
    logic [3:0]   cmd_bank;
    logic [127:0] cmd_be;
    logic         cmd_last;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_cmd_splitter dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
        .cmd_be(cmd_be), .cmd_last(cmd_last)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] span_mask(input int lo, input int hi);
        logic [127:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [1:0] grade(input bit wr, input int cnt);
        if (!wr) return 2'd0;
        if (cnt == 128) return 2'd1;
        if (cnt >= 16) return 2'd2;
        return 2'd3;
    endfunction

    task automatic run_xfer(input logic [31:0] addr, input int len, input bit wr, input int stall_pct);
        logic [31:0]  lastb;
        int           nlines, k;
        bit           held;
        logic [31:0]  h_addr;
        logic [127:0] h_be;
        logic [1:0]   h_kind;
        @(negedge clk);
        check(req_ready === 1'b1, "R10 idle before request", 128'(req_ready), 128'd1);
        req_valid = 1'b1; req_addr = addr; req_len = 16'(len); req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (len == 0) begin
            check(cmd_valid === 1'b0, "R9 zero length issues nothing", 128'(cmd_valid), 128'd0);
            check(req_ready === 1'b1, "R9 zero length stays ready", 128'(req_ready), 128'd1);
            return;
        end
        lastb  = addr + 32'(len) - 1;
        nlines = int'(lastb >> 7) - int'(addr >> 7) + 1;
        k = 0; held = 0;
        h_addr = '0; h_be = '0; h_kind = '0;
        while (1) begin
            logic [31:0]  e_addr;
            int           lo, hi;
            logic [127:0] e_be;
            bit           rdy;
            if (!cmd_valid) begin
                check(0, "R1 command missing", 128'(k), 128'(nlines));
                break;
            end
            check(req_ready === 1'b0, "R10 busy blocks requests", 128'(req_ready), 128'd0);
            if (held) begin
                check(cmd_addr == h_addr && cmd_be == h_be && cmd_kind == h_kind,
                      "R8 held command stable", cmd_be, h_be);
            end
            rdy = ($urandom % 100) >= stall_pct;
            cmd_ready = rdy;
            if (rdy) begin
                e_addr = ((addr >> 7) + 32'(k)) << 7;
                lo = (k == 0) ? int'(addr[6:0]) : 0;
                hi = (k == nlines - 1) ? int'(lastb[6:0]) : 127;
                e_be = span_mask(lo, hi);
                check(cmd_addr == e_addr, "R1 line address", 128'(cmd_addr), 128'(e_addr));
                check(cmd_last == (k == nlines - 1), "R1 last flag", 128'(cmd_last), 128'(k == nlines - 1));
                check(cmd_bank == e_addr[10:7], "R6 bank index", 128'(cmd_bank), 128'(e_addr[10:7]));
                if (k != 0 && k != nlines - 1)
                    check(cmd_be == e_be, "R11 inner line full mask", cmd_be, e_be);
                else
                    check(cmd_be == e_be, "R7 edge mask", cmd_be, e_be);
                case (grade(wr, hi - lo + 1))
                    2'd0: check(cmd_kind == 2'd0, "R5 read kind", 128'(cmd_kind), 128'd0);
                    2'd1: check(cmd_kind == 2'd1, "R2 full write kind", 128'(cmd_kind), 128'd1);
                    2'd2: check(cmd_kind == 2'd2, "R3 masked write kind", 128'(cmd_kind), 128'd2);
                    default: check(cmd_kind == 2'd3, "R4 rmw kind", 128'(cmd_kind), 128'd3);
                endcase
                held = 0;
                k++;
            end else begin
                held = 1;
                h_addr = cmd_addr; h_be = cmd_be; h_kind = cmd_kind;
            end
            @(negedge clk);
            cmd_ready = 1'b0;
            if (rdy && k == nlines) break;
        end
        check(k == nlines, "R1 command count", 128'(k), 128'(nlines));
        check(cmd_valid === 1'b0 && req_ready === 1'b1, "R10 free after last",
              128'({cmd_valid, req_ready}), 128'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_valid === 1'b0, "R10 reset no command", 128'(cmd_valid), 128'd0);
        check(req_ready === 1'b1, "R10 reset ready", 128'(req_ready), 128'd1);

        run_xfer(32'h0000_1000, 256, 1'b1, 0);          // two plain writes
        run_xfer(32'h0000_2005, 1,   1'b1, 30);         // one-byte rmw
        run_xfer(32'h0000_2064, 16,  1'b1, 30);         // exactly threshold, mid-line
        run_xfer(32'h0000_2064, 15,  1'b1, 30);         // one below threshold
        run_xfer(32'h0000_3078, 20,  1'b1, 50);         // straddles edge: two rmw
        run_xfer(32'h0000_0780 + 32'd64, 256, 1'b1, 20); // banks 15,0,1
        run_xfer(32'h0000_4003, 3,   1'b0, 40);         // small read stays read
        run_xfer(32'h0000_5010, 500, 1'b0, 40);         // long read
        run_xfer(32'h0000_6000, 0,   1'b1, 0);          // zero length
        run_xfer(32'h0000_7000, 128, 1'b1, 80);         // one full line, heavy stall

        for (int n = 0; n < 200; n++) begin
            logic [31:0] a = $urandom & 32'h000F_FFFF;
            int          l = int'($urandom % 700);
            bit          w = 1'($urandom);
            run_xfer(a, l, w, int'($urandom % 60));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule